// File: doc/BRIEF.md
# Single-Cycle Integer Datapath

This block is a small programmable core that completes one 32-bit instruction in every clock cycle. Each cycle it fetches the word that the program counter points at, decodes it, reads up to two source registers, runs one ALU operation and then updates three things on the next rising edge. These are the program counter, at most one register, and at most one data-memory word. The register file has 32 entries of 32 bits. Instruction storage and data storage are separate word arrays inside the block.

The instruction subset is small. It has five register-to-register operations (add, subtract, and, or, signed set-less-than) and an add-immediate. It has a word load and a word store that form their address in the main ALU. It also has an equality branch and an absolute jump. While reset is held, a host fills instruction storage through a load port. The host starts the program by releasing reset. Two combinational observation ports return any register and any data word, so the results can be read after a run.

The decoder sorts each instruction into one of seven classes: `IC_RTYPE`, `IC_ADDI`, `IC_LOAD`, `IC_STORE`, `IC_BRANCH`, `IC_JUMP` and `IC_NOP`. There is no multi-cycle state. The only sequential state is the program counter, the register file and the two storage arrays.

Top module: `scdp_core`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is sampled low, the program counter becomes 0 and every register becomes 0. No instruction executes during reset.
- R2: Register 0 always reads as 0. An instruction whose destination is register 0 leaves it at 0.
- R3: An instruction with opcode bits[31:26]=0x00 is a register operation. It writes register rd (bits[15:11]) with a result computed from rs (bits[25:21]) and rt (bits[20:16]). The function field bits[5:0] selects the result: 0x20 gives rs+rt, 0x22 gives rs-rt, 0x24 gives rs AND rt, 0x25 gives rs OR rt, and 0x2A gives 1 if rs<rt as signed numbers and 0 otherwise.
- R4: Opcode 0x08 writes rt with rs plus the sign-extended 16-bit immediate in bits[15:0].
- R5: Opcode 0x23 loads rt from the data word whose index is bits[9:2] of rs plus the sign-extended immediate.
- R6: Opcode 0x2B stores rt to the data word whose index is bits[9:2] of rs plus the sign-extended immediate. It writes no register.
- R7: Opcode 0x04 compares rs with rt by subtraction. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to bits[31:28] of PC+4, followed by the 26-bit field bits[25:0], followed by two zero bits.
- R9: Any other opcode, and any function code other than those listed in R3, writes nothing and advances the PC by 4.
- R10: Every instruction that is neither a branch nor a jump advances the PC by 4. The PC stays word-aligned. Instructions are fetched from the word at PC bits[9:2].
- R11: When `load_we` is high at a rising edge, instruction word `load_addr` takes the value `load_data`.
- R12: `peek_reg_val` combinationally shows the register chosen by `peek_reg_sel`. `peek_mem_val` combinationally shows the data word chosen by `peek_mem_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Instruction-storage write enable |
| load_addr | input | 8 | Instruction word index to write |
| load_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| peek_reg_sel | input | 5 | Register to observe |
| peek_reg_val | output | 32 | Value of the observed register |
| peek_mem_sel | input | 8 | Data word index to observe |
| peek_mem_val | output | 32 | Value of the observed data word |

## Verification
The bench builds the core with its default depths of 256 instruction words and 256 data words. At these depths, a load with a negative offset and a store at a small nonzero word index both land inside the arrays. A program of 24 words also fits, with room left for taken and untaken branches, a forward jump and a closing self-loop branch with a negative offset. Second-program tests then cover a mid-run reset and a reload through the load port.

// File: rtl/scdp_pkg.sv
package scdp_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE  = 6'h00;
    localparam logic [5:0] OP_JUMP   = 6'h02;
    localparam logic [5:0] OP_BRANCH = 6'h04;
    localparam logic [5:0] OP_ADDI   = 6'h08;
    localparam logic [5:0] OP_LOAD   = 6'h23;
    localparam logic [5:0] OP_STORE  = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        IC_NOP,
        IC_RTYPE,
        IC_ADDI,
        IC_LOAD,
        IC_STORE,
        IC_BRANCH,
        IC_JUMP
    } insn_class_e;

    typedef struct packed {
        logic    reg_we;
        logic    mem_we;
        logic    wb_from_mem;
        logic    dst_is_rd;
        logic    alu_src_imm;
        logic    is_branch;
        logic    is_jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scdp_decode.sv
module scdp_decode
    import scdp_pkg::*;
(
    input  logic [5:0]  opcode,
    input  logic [5:0]  funct,
    output ctrl_t       ctrl,
    output insn_class_e cls
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        cls         = IC_NOP;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                cls            = IC_RTYPE;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: begin
                        ctrl.reg_we    = 1'b0;
                        ctrl.dst_is_rd = 1'b0;
                        cls            = IC_NOP;
                    end
                endcase
            end
            OP_ADDI: begin
                ctrl.reg_we      = 1'b1;
                ctrl.alu_src_imm = 1'b1;
                cls              = IC_ADDI;
            end
            OP_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.alu_src_imm = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                cls              = IC_LOAD;
            end
            OP_STORE: begin
                ctrl.mem_we      = 1'b1;
                ctrl.alu_src_imm = 1'b1;
                cls              = IC_STORE;
            end
            OP_BRANCH: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
                cls            = IC_BRANCH;
            end
            OP_JUMP: begin
                ctrl.is_jump = 1'b1;
                cls          = IC_JUMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scdp_alu.sv
module scdp_alu
    import scdp_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scdp_regfile.sv
module scdp_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ra3 == '0) |-> (rd3 == '0)); // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata))); // R3

endmodule

// File: rtl/scdp_core.sv
module scdp_core
    import scdp_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256,
    localparam int IMEM_AW   = $clog2(IMEM_DEPTH),
    localparam int DMEM_AW   = $clog2(DMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_we,
    input  logic [IMEM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]    load_data,
    output logic [XLEN-1:0]    pc_o,
    input  logic [4:0]         peek_reg_sel,
    output logic [XLEN-1:0]    peek_reg_val,
    input  logic [DMEM_AW-1:0] peek_mem_sel,
    output logic [XLEN-1:0]    peek_mem_val
);

    logic [XLEN-1:0] imem [IMEM_DEPTH];
    logic [XLEN-1:0] dmem [DMEM_DEPTH];

    logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm_sext;
    logic [4:0]      f_rs, f_rt, f_rd;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_data, dmem_rdata;
    logic            alu_zero;
    logic [4:0]      wb_addr;
    logic [DMEM_AW-1:0] dmem_idx;
    ctrl_t           ctrl;
    insn_class_e     cls;

    // Fetch
    assign instr    = imem[pc[IMEM_AW+1:2]];
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    always_ff @(posedge clk) begin
        if (load_we) imem[load_addr] <= load_data;
    end

    scdp_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .cls    (cls)
    );

    scdp_regfile #(.NREGS(32), .W(XLEN)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl.reg_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (f_rs),
        .rd1   (rs_val),
        .ra2   (f_rt),
        .rd2   (rt_val),
        .ra3   (peek_reg_sel),
        .rd3   (peek_reg_val)
    );

    assign alu_b = ctrl.alu_src_imm ? imm_sext : rt_val;

    scdp_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data storage: word index from the ALU-formed address
    assign dmem_idx   = alu_y[DMEM_AW+1:2];
    assign dmem_rdata = dmem[dmem_idx];

    always_ff @(posedge clk) begin
        if (rst_n && ctrl.mem_we) dmem[dmem_idx] <= rt_val;
    end

    assign peek_mem_val = dmem[peek_mem_sel];

    // Write-back
    assign wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;
    assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    // Next PC
    assign pc_plus4   = pc + 32'd4;
    assign br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jump)                    pc_next = jmp_target;
        else if (ctrl.is_branch && alu_zero) pc_next = br_target;
        else                                 pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign pc_o = pc;

    logic seq_class;
    assign seq_class = (cls == IC_RTYPE) || (cls == IC_ADDI) || (cls == IC_LOAD)
                    || (cls == IC_STORE) || (cls == IC_NOP);

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00); // R10

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_class |=> (pc == $past(pc) + 32'd4)); // R10

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == IC_BRANCH && rs_val == rt_val)
        |=> (pc == $past(pc) + 32'd4 + {$past(imm_sext[XLEN-3:0]), 2'b00})); // R7

    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == IC_BRANCH && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4)); // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == IC_JUMP) |=> (pc[27:2] == $past(instr[25:0]))); // R8

    AST_STORE_NO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == IC_STORE) |-> !ctrl.reg_we); // R6

    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == IC_NOP) |-> !(ctrl.reg_we || ctrl.mem_we)); // R9

endmodule

// File: tb/scdp_core_bench.sv
module scdp_core_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o;
    logic [4:0]  peek_reg_sel = '0;
    logic [31:0] peek_reg_val;
    logic [7:0]  peek_mem_sel = '0;
    logic [31:0] peek_mem_val;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scdp_core u_scdp_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_we      (load_we),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .pc_o         (pc_o),
        .peek_reg_sel (peek_reg_sel),
        .peek_reg_val (peek_reg_val),
        .peek_mem_sel (peek_mem_sel),
        .peek_mem_val (peek_mem_val)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    localparam int PLEN = 24;
    localparam logic [31:0] PROG [PLEN] = '{
        enc_i(6'h08, 0, 1, 5),        // 0  r1 = 5
        enc_i(6'h08, 0, 2, -3),       // 1  r2 = -3
        enc_r(1, 2, 3, 6'h20),        // 2  r3 = r1 + r2
        enc_r(2, 1, 4, 6'h22),        // 3  r4 = r2 - r1
        enc_r(1, 2, 5, 6'h24),        // 4  r5 = r1 & r2
        enc_r(1, 2, 6, 6'h25),        // 5  r6 = r1 | r2
        enc_r(2, 1, 7, 6'h2A),        // 6  r7 = (r2 < r1)
        enc_r(1, 2, 8, 6'h2A),        // 7  r8 = (r1 < r2)
        enc_i(6'h08, 0, 0, 7),        // 8  r0 write attempt
        enc_i(6'h2B, 0, 1, 8),        // 9  mem[2] = r1
        enc_i(6'h2B, 0, 4, 12),       // 10 mem[3] = r4
        enc_i(6'h23, 0, 9, 8),        // 11 r9 = mem[2]
        enc_i(6'h08, 0, 10, 16),      // 12 r10 = 16
        enc_i(6'h23, 10, 11, -4),     // 13 r11 = mem[3]
        enc_i(6'h04, 1, 3, 5),        // 14 not taken
        enc_i(6'h04, 1, 9, 1),        // 15 taken to 17
        enc_i(6'h08, 0, 12, 99),      // 16 skipped
        enc_j(20),                    // 17 jump to 20
        enc_i(6'h08, 0, 13, 1),       // 18 skipped
        enc_i(6'h08, 0, 13, 2),       // 19 skipped
        enc_i(6'h3F, 0, 14, 55),      // 20 unknown opcode
        enc_r(1, 1, 15, 6'h3F),       // 21 unknown function
        enc_i(6'h08, 0, 16, 32'h7FFF),// 22 r16 = 0x7FFF
        enc_i(6'h04, 0, 0, -1)        // 23 self loop
    };

    typedef struct packed {
        logic [7:0]  req;
        logic [4:0]  sel;
        logic [31:0] val;
    } reg_exp_t;

    localparam int NEXP = 17;
    localparam reg_exp_t EXP [NEXP] = '{
        '{8'd4, 5'd1,  32'd5},          // R4
        '{8'd4, 5'd2,  32'hFFFF_FFFD},  // R4 sign extension
        '{8'd3, 5'd3,  32'd2},          // R3 add
        '{8'd3, 5'd4,  32'hFFFF_FFF8},  // R3 sub
        '{8'd3, 5'd5,  32'd5},          // R3 and
        '{8'd3, 5'd6,  32'hFFFF_FFFD},  // R3 or
        '{8'd3, 5'd7,  32'd1},          // R3 slt true
        '{8'd3, 5'd8,  32'd0},          // R3 slt false
        '{8'd2, 5'd0,  32'd0},          // R2
        '{8'd5, 5'd9,  32'd5},          // R5
        '{8'd4, 5'd10, 32'd16},         // R4
        '{8'd5, 5'd11, 32'hFFFF_FFF8},  // R5 negative offset
        '{8'd7, 5'd12, 32'd0},          // R7 skipped by branch
        '{8'd8, 5'd13, 32'd0},          // R8 skipped by jump
        '{8'd9, 5'd14, 32'd0},          // R9 unknown opcode
        '{8'd9, 5'd15, 32'd0},          // R9 unknown function
        '{8'd4, 5'd16, 32'h0000_7FFF}   // R4 largest positive immediate
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek_reg(input int sel, output logic [31:0] v);
        peek_reg_sel = 5'(sel);
        #1;
        v = peek_reg_val;
    endtask

    task automatic peek_mem(input int sel, output logic [31:0] v);
        peek_mem_sel = 8'(sel);
        #1;
        v = peek_mem_val;
    endtask

    task automatic load_word(input int addr, input logic [31:0] data);
        load_we   = 1'b1;
        load_addr = 8'(addr);
        load_data = data;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 pc after reset", pc_o, 32'd0);
        peek_reg(5, v);
        chk("R1 register after reset", v, 32'd0);

        // R11: fill instruction storage during reset
        for (int i = 0; i < PLEN; i++) load_word(i, PROG[i]);
        chk("R1 pc held in reset", pc_o, 32'd0);

        rst_n = 1'b1;
        repeat (60) @(negedge clk);

        for (int i = 0; i < NEXP; i++) begin
            string tag;
            peek_reg(int'(EXP[i].sel), v);
            tag = $sformatf("R%0d reg %0d", EXP[i].req, EXP[i].sel);
            chk(tag, v, EXP[i].val);
        end

        // R6 / R12: stored data words
        peek_mem(2, v);
        chk("R6 mem word 2", v, 32'd5);
        peek_mem(3, v);
        chk("R6 mem word 3", v, 32'hFFFF_FFF8);

        // R7: self-loop with negative offset holds the PC
        chk("R7 pc at self loop", pc_o, 32'd92);
        repeat (3) @(negedge clk);
        chk("R7 pc still at self loop", pc_o, 32'd92);

        // R1: mid-run reset clears state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 pc after mid-run reset", pc_o, 32'd0);
        peek_reg(3, v);
        chk("R1 reg cleared by reset", v, 32'd0);

        // R11 / R10: reload two words and run again
        load_word(0, enc_i(6'h08, 0, 20, 42));
        load_word(1, enc_i(6'h04, 0, 0, -1));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 pc after one instruction", pc_o, 32'd4);
        repeat (4) @(negedge clk);
        peek_reg(20, v);
        chk("R11 reloaded program result", v, 32'd42);
        chk("R10 pc at reloaded loop", pc_o, 32'd4);
        peek_reg(1, v);
        chk("R11 untouched register stays cleared", v, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule